// File: doc/BRIEF.md
# Single-Slave Bus Bridge with Wait Watchdog

This block sits between a pipelined AHB-Lite style master and one piece of user logic. It serves a single address window. It registers each accepted address phase into a data phase. During the data phase it presents the user logic with a select, one read or write strobe, the transfer size, the burst type, the beat address and the write data. Two flags mark the beat: one for the first beat of a burst and one for every beat that continues a burst. Burst beat addresses after the first are produced inside the bridge, with incrementing or wrapping arithmetic, and do not come from the master's address bus.

The user logic holds a stall input high to stretch a data phase. A watchdog counts the stalled cycles and ends the transfer after a fixed bound, unless the user logic asserts a no-limit input. If that input is high, the transfer may stall for as long as the user logic wants. A transfer ended by the watchdog sets a timeout flag, and only reset clears it. Read data from the user logic is returned to the master in the cycle the transfer completes, whether it ended normally or was forced.

Top module: `adp_slave_bridge`

## Requirements
- R1: A beat is forwarded only when `hsel` is high, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), and `haddr[31:16]` equals the window base 16'h4000. Otherwise `usr_sel` stays low and `hreadyout` stays high.
- R2: In the data phase of a forwarded beat, `usr_sel` is high and exactly one of `usr_rd` or `usr_wr` is high, chosen by the registered `hwrite`. `usr_size` carries the registered `hsize`, and `usr_wdata` carries `hwdata`.
- R3: `usr_first` is high in the data phase of a NONSEQ beat whose `hburst` is not SINGLE (3'b000). `usr_next` is high in the data phase of every SEQ beat. The two flags are never high together.
- R4: While `usr_stall` is high and the watchdog has not fired, `hreadyout` is low and `usr_addr` holds its value. The transfer completes in the first data-phase cycle with `usr_stall` low.
- R5: When `usr_nolimit` is low, a transfer completes after at most 16 stalled cycles, in its 17th data-phase cycle.
- R6: While `usr_nolimit` is high, a stalled transfer never completes. If `usr_nolimit` falls after 16 or more stalled cycles, the transfer completes in that same cycle.
- R7: `tmo_sticky` goes high after a transfer that the watchdog completed while `usr_stall` was high. It stays high until reset.
- R8: In the cycle a read completes, `hrdata` equals `usr_rdata`. This holds for normal and forced completion.
- R9: For SEQ beats of INCR bursts (`hburst` 1, 3, 5, 7), `usr_addr` advances by the size in bytes. `hsize` 0 gives 1 byte, 1 gives 2 bytes, and 2 or more gives 4 bytes.
- R10: For SEQ beats of WRAP4, WRAP8 and WRAP16 (`hburst` 2, 4, 6), `usr_addr` advances by the size and wraps within an aligned block of beats × bytes.
- R11: After reset, `usr_sel` is low, `hreadyout` is high and `tmo_sticky` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Master select for this bridge |
| haddr | input | 32 | Master address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | Transfer size code |
| hburst | input | 3 | Burst type code |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data to the master |
| hreadyout | output | 1 | Data phase complete |
| usr_sel | output | 1 | A beat is in its data phase |
| usr_addr | output | 32 | Beat address |
| usr_wdata | output | 32 | Beat write data |
| usr_rdata | input | 32 | Read data from user logic |
| usr_rd | output | 1 | Read strobe |
| usr_wr | output | 1 | Write strobe |
| usr_size | output | 3 | Beat size code |
| usr_burst | output | 3 | Burst type code |
| usr_first | output | 1 | First beat of a burst |
| usr_next | output | 1 | Continuing beat of a burst |
| usr_stall | input | 1 | User logic inserts a wait state |
| usr_nolimit | input | 1 | Disable the wait watchdog |
| tmo_sticky | output | 1 | Sticky watchdog-timeout flag |

## Verification
The assertions assume the master follows the pipelined protocol. It presents a new address phase only when `hreadyout` was high, and it keeps `hsize` and `hburst` constant across the beats of one burst. They also assume `usr_stall` and `usr_nolimit` are meaningful only while `usr_sel` is high. The bench's driver waits for `hreadyout` before it moves to the next beat and gives every burst one fixed size and type. Its slave model drives `usr_stall` and `usr_nolimit` only from a per-transfer stall count, so the stimulus stays inside those assumptions. Wrapping bursts start at unaligned offsets so that the wrap point falls inside the burst.

// File: rtl/adp_pkg.sv
// Shared encodings and helpers for the single-slave bus bridge.
// Assumes AHB-style htrans/hburst codes.
package adp_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'd0,
        BU_INCR   = 3'd1,
        BU_WRAP4  = 3'd2,
        BU_INCR4  = 3'd3,
        BU_WRAP8  = 3'd4,
        BU_INCR8  = 3'd5,
        BU_WRAP16 = 3'd6,
        BU_INCR16 = 3'd7
    } burst_e;

    // log2 of bytes per beat; sizes wider than a word are treated as a word
    function automatic logic [1:0] size_lg(input logic [2:0] sz);
        return (sz > 3'd2) ? 2'd2 : sz[1:0];
    endfunction

    // log2 of beats in a wrapping burst, zero for non-wrapping types
    function automatic logic [2:0] wrap_beats_lg(input logic [2:0] bu);
        case (bu)
            BU_WRAP4:  return 3'd2;
            BU_WRAP8:  return 3'd3;
            BU_WRAP16: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/adp_addr_step.sv
// Next-beat address generator.
// Given the previous beat's address, size and burst type, it returns the address of
// the following SEQ beat. Wrapping bursts stay within an aligned block of
// beats x bytes. Assumes the burst start address is aligned to the size.
module adp_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    size,
    input  logic [2:0]    burst,
    output logic [AW-1:0] nxt_addr
);
    import adp_pkg::*;

    logic [1:0]    slg;
    logic [2:0]    blg;
    logic [AW-1:0] inc;
    logic [AW-1:0] sum;
    logic [AW-1:0] mask;

    // Purpose: add one beat and, for wrapping bursts, fold back into the block.
    always_comb begin
        slg  = size_lg(size);
        blg  = wrap_beats_lg(burst);
        inc  = AW'(1) << slg;
        sum  = cur_addr + inc;
        mask = '0;
        if (blg != 3'd0) begin
            mask     = (AW'(1) << (blg + 3'(slg))) - AW'(1);
            nxt_addr = (cur_addr & ~mask) | (sum & mask);
        end else begin
            nxt_addr = sum;
        end
    end
endmodule

// File: rtl/adp_wait_wdog.sv
// Wait-state watchdog.
// Counts stalled data-phase cycles, saturating at MAX_WAIT. It reports completion
// when the stall drops or, with no-limit low, once MAX_WAIT stalls have passed.
// Assumes `active` is high exactly during data phases.
module adp_wait_wdog #(
    parameter int MAX_WAIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic stall,
    input  logic nolimit,
    output logic done,
    output logic forced
);
    localparam int CW = $clog2(MAX_WAIT + 1);

    logic [CW-1:0] cnt;
    logic          at_lim;

    assign at_lim = (cnt == CW'(MAX_WAIT));
    assign forced = active & stall & at_lim & ~nolimit;
    assign done   = active & (~stall | forced);

    // Purpose: count stalled cycles of the current transfer, clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || done) begin
            cnt <= '0;
        end else if (!at_lim) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/adp_win_dec.sv
// Address-phase decoder.
// It flags a beat to forward when the bridge is selected, the transfer type is
// NONSEQ or SEQ, and the address is in the 2**WIN_LG byte window at BASE_ADDR.
module adp_win_dec #(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  BASE_ADDR = 32'h4000_0000,
    parameter int             WIN_LG    = 16
) (
    input  logic          hsel,
    input  logic [1:0]    htrans,
    input  logic [AW-1:0] haddr,
    output logic          hit
);
    logic in_win;

    assign in_win = (haddr[AW-1:WIN_LG] == BASE_ADDR[AW-1:WIN_LG]);
    assign hit    = hsel & htrans[1] & in_win;
endmodule

// File: rtl/adp_slave_bridge.sv
// Single-slave bus bridge (top).
// It registers an accepted address phase into the data phase and drives the user
// strobes and flags from that register. The user logic stretches a transfer with
// usr_stall, and the wait watchdog ends it early unless usr_nolimit is high.
// Assumes one master that waits for hreadyout before it issues a new address phase.
module adp_slave_bridge #(
    parameter int             AW        = 32,
    parameter int             DW        = 32,
    parameter int             MAX_WAIT  = 16,
    parameter logic [AW-1:0]  BASE_ADDR = 32'h4000_0000,
    parameter int             WIN_LG    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsel,
    input  logic [AW-1:0] haddr,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic [2:0]    hsize,
    input  logic [2:0]    hburst,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata,
    output logic          hreadyout,
    output logic          usr_sel,
    output logic [AW-1:0] usr_addr,
    output logic [DW-1:0] usr_wdata,
    input  logic [DW-1:0] usr_rdata,
    output logic          usr_rd,
    output logic          usr_wr,
    output logic [2:0]    usr_size,
    output logic [2:0]    usr_burst,
    output logic          usr_first,
    output logic          usr_next,
    input  logic          usr_stall,
    input  logic          usr_nolimit,
    output logic          tmo_sticky
);
    import adp_pkg::*;

    logic          hit;
    logic          done;
    logic          forced;
    logic [AW-1:0] step_addr;

    logic          dp_act;
    logic          dp_wr;
    logic [2:0]    dp_size;
    logic [2:0]    dp_burst;
    logic [AW-1:0] dp_addr;
    logic          dp_first;
    logic          dp_next;

    adp_win_dec #(
        .AW(AW), .BASE_ADDR(BASE_ADDR), .WIN_LG(WIN_LG)
    ) dec_i (
        .hsel(hsel), .htrans(htrans), .haddr(haddr), .hit(hit)
    );

    adp_addr_step #(.AW(AW)) step_i (
        .cur_addr(dp_addr), .size(dp_size), .burst(dp_burst), .nxt_addr(step_addr)
    );

    adp_wait_wdog #(.MAX_WAIT(MAX_WAIT)) wdog_i (
        .clk(clk), .rst_n(rst_n), .active(dp_act), .stall(usr_stall),
        .nolimit(usr_nolimit), .done(done), .forced(forced)
    );

    assign hreadyout = ~dp_act | done;
    assign hrdata    = usr_rdata;

    assign usr_sel   = dp_act;
    assign usr_rd    = dp_act & ~dp_wr;
    assign usr_wr    = dp_act & dp_wr;
    assign usr_first = dp_act & dp_first;
    assign usr_next  = dp_act & dp_next;
    assign usr_addr  = dp_addr;
    assign usr_size  = dp_size;
    assign usr_burst = dp_burst;
    assign usr_wdata = hwdata;

    // Purpose: open a data phase on an accepted beat; hold the burst context otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_act   <= 1'b0;
            dp_wr    <= 1'b0;
            dp_size  <= '0;
            dp_burst <= '0;
            dp_addr  <= '0;
            dp_first <= 1'b0;
            dp_next  <= 1'b0;
        end else if (hreadyout) begin
            dp_act <= hit;
            if (hit) begin
                dp_wr    <= hwrite;
                dp_size  <= hsize;
                dp_burst <= hburst;
                dp_addr  <= (htrans == TR_SEQ) ? step_addr : haddr;
                dp_first <= (htrans == TR_NSEQ) && (hburst != BU_SINGLE);
                dp_next  <= (htrans == TR_SEQ);
            end
        end
    end

    // Purpose: remember that the watchdog ended a stalled transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_sticky <= 1'b0;
        end else if (forced) begin
            tmo_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/adp_slave_bridge_chk.sv
// Protocol checker for adp_slave_bridge, attached with bind.
// It keeps its own count of stalled cycles in the current data phase.
module adp_slave_bridge_chk #(
    parameter int AW       = 32,
    parameter int MAX_WAIT = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hreadyout,
    input logic          usr_sel,
    input logic          usr_rd,
    input logic          usr_wr,
    input logic          usr_first,
    input logic          usr_next,
    input logic          usr_stall,
    input logic          usr_nolimit,
    input logic [AW-1:0] usr_addr,
    input logic          tmo_sticky
);
    localparam int SW = $clog2(MAX_WAIT + 1) + 1;

    logic [SW-1:0] seen;

    // Purpose: count stalled cycles seen since the current data phase began.
    always_ff @(posedge clk) begin
        if (!rst_n || !usr_sel || hreadyout) begin
            seen <= '0;
        end else if (seen < SW'(MAX_WAIT)) begin
            seen <= seen + SW'(1);
        end
    end

    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !usr_sel |-> hreadyout);

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((usr_rd || usr_wr) == usr_sel) && !(usr_rd && usr_wr));

    p_flag_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_first || usr_next) |-> (usr_sel && !(usr_first && usr_next)));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_sel && !hreadyout) |=> (usr_sel && $stable(usr_addr)));

    p_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_sel && !usr_stall) |-> hreadyout);

    p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_sel && !usr_nolimit && (seen >= SW'(MAX_WAIT))) |-> hreadyout);

    p_no_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_sel && usr_stall && usr_nolimit) |-> !hreadyout);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_sticky |=> tmo_sticky);
endmodule

bind adp_slave_bridge adp_slave_bridge_chk #(.AW(AW), .MAX_WAIT(MAX_WAIT)) chk_i (
    .clk(clk), .rst_n(rst_n), .hreadyout(hreadyout), .usr_sel(usr_sel),
    .usr_rd(usr_rd), .usr_wr(usr_wr), .usr_first(usr_first), .usr_next(usr_next),
    .usr_stall(usr_stall), .usr_nolimit(usr_nolimit), .usr_addr(usr_addr),
    .tmo_sticky(tmo_sticky)
);

// File: tb/adp_slave_bridge_tb_top.sv
// Scoreboard bench: the driver queues one expected item per beat, and the
// negedge slave model and monitor compare each completion against it.
module adp_slave_bridge_tb_top;

    localparam int MAXW = 16;

    typedef struct {
        logic [31:0] addr;
        logic        wr;
        logic        first;
        logic        nxt;
        logic [2:0]  size;
        int          want;
        int          exp_w;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = '0;
    logic [2:0]  hburst = '0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        usr_sel;
    logic [31:0] usr_addr;
    logic [31:0] usr_wdata;
    logic [31:0] usr_rdata = '0;
    logic        usr_rd;
    logic        usr_wr;
    logic [2:0]  usr_size;
    logic [2:0]  usr_burst;
    logic        usr_first;
    logic        usr_next;
    logic        usr_stall = 1'b0;
    logic        usr_nolimit = 1'b0;
    logic        tmo_sticky;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    stall_cnt = 0;
    int    nolim_until = 0;
    bit    done_flag = 1'b0;

    always #10 clk = ~clk;

    adp_slave_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
        .hrdata(hrdata), .hreadyout(hreadyout), .usr_sel(usr_sel),
        .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
        .usr_rd(usr_rd), .usr_wr(usr_wr), .usr_size(usr_size), .usr_burst(usr_burst),
        .usr_first(usr_first), .usr_next(usr_next), .usr_stall(usr_stall),
        .usr_nolimit(usr_nolimit), .tmo_sticky(tmo_sticky)
    );

    function automatic logic [31:0] wr_pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return ~a + 32'h0000_1234;
    endfunction

    // R9/R10: beat address computed from the start address
    function automatic logic [31:0] beat_addr(input logic [31:0] a0, input logic [2:0] sz,
                                              input logic [2:0] bu, input int i);
        int unsigned bytes;
        int unsigned nb;
        int unsigned bnd;
        logic [31:0] base;
        bytes = (sz > 3'd2) ? 4 : (1 << sz);
        nb = (bu == 3'd2) ? 4 : (bu == 3'd4) ? 8 : (bu == 3'd6) ? 16 : 0;
        if (nb == 0) return a0 + 32'(i * bytes);
        bnd  = nb * bytes;
        base = a0 - (a0 % bnd);
        return base + ((a0 - base + 32'(i * bytes)) % bnd);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Slave model, then monitor: stall from the queued want count, then compare on completion
    always @(negedge clk) begin
        if (usr_sel && q.size() > 0) begin
            usr_stall   = (stall_cnt < q[0].want);
            usr_nolimit = (stall_cnt < nolim_until);
            usr_rdata   = rd_pat(usr_addr);
        end else begin
            usr_stall   = 1'b0;
            usr_nolimit = 1'b0;
        end
        #1;
        if (rst_n && usr_sel && hreadyout) begin
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected beat", usr_addr, 32'h0);
            end else begin
                item_t it;
                it = q.pop_front();
                check(usr_addr == it.addr, "R9/R10", "usr_addr", usr_addr, it.addr);
                check(usr_wr == it.wr && usr_rd == !it.wr, "R2", "strobe", {30'd0, usr_rd, usr_wr},
                      {30'd0, !it.wr, it.wr});
                check(usr_size == it.size, "R2", "usr_size", 32'(usr_size), 32'(it.size));
                check(usr_first == it.first && usr_next == it.nxt, "R3", "flags",
                      {30'd0, usr_first, usr_next}, {30'd0, it.first, it.nxt});
                check(stall_cnt == it.exp_w, "R4/R5/R6", "stall cycles",
                      32'(stall_cnt), 32'(it.exp_w));
                if (it.wr)
                    check(usr_wdata == wr_pat(it.addr), "R2", "usr_wdata", usr_wdata, wr_pat(it.addr));
                else
                    check(hrdata == rd_pat(it.addr), "R8", "hrdata", hrdata, rd_pat(it.addr));
            end
            stall_cnt = 0;
        end else if (usr_sel) begin
            stall_cnt++;
        end
    end

    task automatic wait_ready();
        bit r;
        do begin
            @(negedge clk);
            #2;
            r = hreadyout;
            @(posedge clk);
            #1;
        end while (!r);
    endtask

    // Driver: one burst, the same stall demand on every beat
    task automatic xfer(input logic [31:0] a0, input logic [2:0] sz, input logic [2:0] bu,
                        input int nbeats, input bit wr, input int want);
        logic [31:0] prev;
        prev = '0;
        for (int i = 0; i < nbeats; i++) begin
            item_t it;
            it.addr  = beat_addr(a0, sz, bu, i);
            it.wr    = wr;
            it.first = (i == 0) && (bu != 3'd0);
            it.nxt   = (i != 0);
            it.size  = sz;
            it.want  = want;
            if (want <= MAXW) it.exp_w = want;
            else it.exp_w = (want < ((nolim_until > MAXW) ? nolim_until : MAXW)) ? want
                          : ((nolim_until > MAXW) ? nolim_until : MAXW);
            q.push_back(it);
            hsel   = 1'b1;
            htrans = (i == 0) ? 2'b10 : 2'b11;
            haddr  = (i == 0) ? a0 : 32'h4000_FFF0;
            hwrite = wr;
            hsize  = sz;
            hburst = bu;
            if (i > 0) hwdata = wr_pat(prev);
            wait_ready();
            prev = it.addr;
        end
        hsel   = 1'b0;
        htrans = 2'b00;
        hwdata = wr_pat(prev);
        wait_ready();
    endtask

    // R1: a beat that must not be forwarded
    task automatic probe_ignored(input bit s, input logic [1:0] t, input logic [31:0] a);
        hsel = s; htrans = t; haddr = a; hwrite = 1'b0; hburst = 3'd0; hsize = 3'd2;
        @(posedge clk); #1;
        hsel = 1'b0; htrans = 2'b00;
        @(negedge clk); #2;
        check(!usr_sel, "R1", "usr_sel on ignored beat", 32'(usr_sel), 32'h0);
        check(hreadyout, "R1", "hreadyout on ignored beat", 32'(hreadyout), 32'h1);
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "WDOG", "bench watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(!usr_sel && hreadyout && !tmo_sticky, "R11", "reset state",
              {29'd0, usr_sel, hreadyout, tmo_sticky}, 32'h2);
        @(posedge clk); #1;

        xfer(32'h4000_0100, 3'd2, 3'd0, 1, 1'b0, 0);   // R2 single read
        xfer(32'h4000_0104, 3'd2, 3'd0, 1, 1'b1, 3);   // R2/R4 single write with waits
        xfer(32'h4000_0200, 3'd2, 3'd3, 4, 1'b1, 1);   // R9 INCR4 words
        xfer(32'h4000_0302, 3'd1, 3'd5, 8, 1'b0, 0);   // R9 INCR8 halfwords
        xfer(32'h4000_0407, 3'd0, 3'd1, 5, 1'b1, 2);   // R9 INCR bytes
        xfer(32'h4000_0518, 3'd2, 3'd2, 4, 1'b0, 0);   // R10 WRAP4 words
        xfer(32'h4000_060C, 3'd1, 3'd4, 8, 1'b1, 1);   // R10 WRAP8 halfwords
        xfer(32'h4000_072E, 3'd0, 3'd6, 16, 1'b0, 0);  // R10 WRAP16 bytes
        xfer(32'h4000_0838, 3'd2, 3'd7, 16, 1'b0, 0);  // R9 INCR16 words

        probe_ignored(1'b1, 2'b10, 32'h5000_0000);     // R1 outside window
        probe_ignored(1'b0, 2'b10, 32'h4000_0010);     // R1 not selected
        probe_ignored(1'b1, 2'b00, 32'h4000_0010);     // R1 idle
        probe_ignored(1'b1, 2'b01, 32'h4000_0010);     // R1 busy

        xfer(32'h4000_0900, 3'd2, 3'd0, 1, 1'b0, 16);  // R4 exactly at the bound
        check(!tmo_sticky, "R7", "no timeout at bound", 32'(tmo_sticky), 32'h0);

        nolim_until = 1000;
        xfer(32'h4000_0A00, 3'd2, 3'd0, 1, 1'b0, 40);  // R6 unlimited waits
        check(!tmo_sticky, "R7", "no timeout with no-limit", 32'(tmo_sticky), 32'h0);

        nolim_until = 0;
        xfer(32'h4000_0B00, 3'd2, 3'd0, 1, 1'b0, 25);  // R5 forced after 16, R8 read data
        check(tmo_sticky, "R7", "timeout set", 32'(tmo_sticky), 32'h1);

        nolim_until = 22;
        xfer(32'h4000_0C00, 3'd2, 3'd0, 1, 1'b1, 40);  // R6 no-limit falls late
        nolim_until = 0;
        xfer(32'h4000_0D00, 3'd2, 3'd3, 4, 1'b0, 0);
        check(tmo_sticky, "R7", "timeout stays set", 32'(tmo_sticky), 32'h1);

        check(q.size() == 0, "R2", "beats left outstanding", 32'(q.size()), 32'h0);
        finish_run();
    end
endmodule